// File: doc/BRIEF.md
# Two-Wire Transition-Coded Serial Link

This block is a matched encoder and decoder that move one serial data bit per clock interval across a pair of wires. A bit is carried by which wires change level, not by the levels themselves. A logic 1 toggles both wires. A logic 0 toggles exactly one wire, and the chosen wire alternates from one zero to the next so that both lines stay active. Because the decoder only looks at which wires changed, it recovers the same bit stream when the two wires are swapped, when either wire is inverted, or when both impairments are present.

Both ends share one global clock and one synchronous active-high reset. Between them sits a test channel stage with static settings: swap the wires, invert either wire on its own, and a hold control that freezes the received pair for a cycle to emulate a dropout. The decoder flags any interval in which neither wire changed with a sticky error bit. Its recovered output follows the input after a fixed latency. That latency is set once, through a parameter, to 1, 2 or 3 cycles.

The encoder state machine has two states. `ZSEL_A` means the next zero toggles wire A. `ZSEL_B` means the next zero toggles wire B. Encoding a 0 moves the machine A→B or B→A. Encoding a 1 leaves the state unchanged, and reset enters `ZSEL_A`. The decoder state machine also has two states. `DEC_PRIME` captures the first received pair after reset and produces no valid output. `DEC_RUN` decodes every later interval. The only transitions are PRIME→RUN on the first clock after reset and RUN→RUN after that. Reset returns the machine to `DEC_PRIME`.

Top module: `twl_link`

## Requirements
- R1: In every clock interval after reset is released, at least one of `line_a` and `line_b` differs from its value in the previous interval.
- R2: When `din` is 1 at a clock edge, both `line_a` and `line_b` invert at that edge.
- R3: When `din` is 0 at a clock edge, exactly one line inverts. The first zero after reset toggles `line_a`, and later zeros alternate between `line_b` and `line_a`. Ones between zeros do not affect the alternation.
- R4: While `rst` is high, `line_a`, `line_b`, `dout`, `dout_valid` and `line_error` are all 0 after the next clock edge.
- R5: With `OUT_DELAY` = D, the value of `dout` after clock edge n (n counted from 1 at the first edge after reset is released) equals `din` sampled at edge n−D.
- R6: `dout_valid` is 0 after edges 1 through D following reset release, and it is 1 from edge D+1 onward.
- R7: The recovered stream of R5 is identical for all eight combinations of `chan_swap`, `chan_inv_a` and `chan_inv_b`.
- R8: `line_error` becomes 1 after any decoded interval in which neither received wire changed, for example one cycle with `chan_hold` = 1. It stays 1 until reset.
- R9: With `chan_hold` low, `line_error` stays 0 during normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both link ends |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data into the encoder, one bit per clock |
| chan_swap | input | 1 | Test channel: exchange the two wires |
| chan_inv_a | input | 1 | Test channel: invert received wire A |
| chan_inv_b | input | 1 | Test channel: invert received wire B |
| chan_hold | input | 1 | Test channel: repeat the previously received pair |
| line_a | output | 1 | Encoder line output A |
| line_b | output | 1 | Encoder line output B |
| dout | output | 1 | Recovered serial data |
| dout_valid | output | 1 | Recovered data is meaningful |
| line_error | output | 1 | Sticky flag for an interval with no line change |

## Verification
The embedded properties check on every cycle that the encoder always toggles at least one line, that a 1 toggles both lines, and that a 0 toggles exactly one. They also check that the decoder flags a frozen line pair, and that both the valid flag and the error flag stay set once raised. Three behaviours can only be shown by the bench's scenarios, which compare against a model of the stream: the alternation order of zeros, the exact output latency, and the fact that the recovered data does not change under every swap and inversion setting.

// File: rtl/twl_pkg.sv
`timescale 1ns/1ps
package twl_pkg;
    // Encoder: which wire the next zero toggles
    typedef enum logic {
        ZSEL_A = 1'b0,
        ZSEL_B = 1'b1
    } zsel_e;

    // Decoder: priming the previous-pair register, then decoding
    typedef enum logic {
        DEC_PRIME = 1'b0,
        DEC_RUN   = 1'b1
    } dec_e;

    typedef struct packed {
        logic a;
        logic b;
    } pair_t;
endpackage

// File: rtl/twl_encoder.sv
`timescale 1ns/1ps
module twl_encoder
    import twl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output pair_t line
);
    zsel_e zsel_q, zsel_d;
    pair_t line_q, line_d;

    // next-state and next-line logic
    always_comb begin
        zsel_d = zsel_q;
        line_d = line_q;
        if (din) begin
            line_d.a = ~line_q.a;
            line_d.b = ~line_q.b;
        end else begin
            unique case (zsel_q)
                ZSEL_A: begin
                    line_d.a = ~line_q.a;
                    zsel_d   = ZSEL_B;
                end
                ZSEL_B: begin
                    line_d.b = ~line_q.b;
                    zsel_d   = ZSEL_A;
                end
                default: zsel_d = ZSEL_A;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) zsel_q <= ZSEL_A;
        else     zsel_q <= zsel_d;
    end

    // line output registers
    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= line_d;
    end

    assign line = line_q;

    a_r1_line_activity: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((line_q.a != $past(line_q.a)) || (line_q.b != $past(line_q.b))));

    a_r2_one_both_toggle: assert property (@(posedge clk) disable iff (rst)
        din |=> ((line_q.a != $past(line_q.a)) && (line_q.b != $past(line_q.b))));

    a_r3_zero_single_toggle: assert property (@(posedge clk) disable iff (rst)
        !din |=> ($countones({line_q.a ^ $past(line_q.a), line_q.b ^ $past(line_q.b)}) == 1));
endmodule

// File: rtl/twl_channel.sv
`timescale 1ns/1ps
module twl_channel
    import twl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pair_t tx,
    input  logic  swap,
    input  logic  inv_a,
    input  logic  inv_b,
    input  logic  hold,
    output pair_t rx
);
    pair_t live;
    pair_t held_q;

    always_comb begin
        live.a = (swap ? tx.b : tx.a) ^ inv_a;
        live.b = (swap ? tx.a : tx.b) ^ inv_b;
        rx     = hold ? held_q : live;
    end

    // last delivered pair, replayed while hold is high
    always_ff @(posedge clk) begin
        if (rst) held_q <= live;
        else     held_q <= rx;
    end
endmodule

// File: rtl/twl_decoder.sv
`timescale 1ns/1ps
module twl_decoder
    import twl_pkg::*;
#(
    parameter int OUT_DELAY = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  pair_t rx,
    output logic  dout,
    output logic  dout_valid,
    output logic  line_error
);
    localparam int EXTRA = OUT_DELAY - 1;

    dec_e  dec_q, dec_d;
    pair_t prev_q;
    logic  base_dout, base_vld, err_q;
    logic  [1:0] flip;

    assign flip = {rx.a ^ prev_q.a, rx.b ^ prev_q.b};

    // next state
    always_comb begin
        unique case (dec_q)
            DEC_PRIME: dec_d = DEC_RUN;
            DEC_RUN:   dec_d = DEC_RUN;
            default:   dec_d = DEC_PRIME;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) dec_q <= DEC_PRIME;
        else     dec_q <= dec_d;
    end

    // output and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= '0;
            base_dout <= 1'b0;
            base_vld  <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            prev_q <= rx;
            unique case (dec_q)
                DEC_PRIME: begin
                    base_vld  <= 1'b0;
                    base_dout <= 1'b0;
                end
                DEC_RUN: begin
                    base_vld  <= 1'b1;
                    base_dout <= &flip;
                    if (flip == 2'b00) err_q <= 1'b1;
                end
                default: base_vld <= 1'b0;
            endcase
        end
    end

    // optional output delay stages
    generate
        if (EXTRA > 0) begin : g_delay
            logic [EXTRA:1] d_sr;
            logic [EXTRA:1] v_sr;
            always_ff @(posedge clk) begin
                if (rst) begin
                    d_sr <= '0;
                    v_sr <= '0;
                end else begin
                    d_sr[1] <= base_dout;
                    v_sr[1] <= base_vld;
                    for (int i = 2; i <= EXTRA; i++) begin
                        d_sr[i] <= d_sr[i-1];
                        v_sr[i] <= v_sr[i-1];
                    end
                end
            end
            assign dout       = d_sr[EXTRA];
            assign dout_valid = v_sr[EXTRA];
        end else begin : g_direct
            assign dout       = base_dout;
            assign dout_valid = base_vld;
        end
    endgenerate

    assign line_error = err_q;

    a_r8_error_sticky: assert property (@(posedge clk) disable iff (rst)
        line_error |=> line_error);

    a_r8_stall_flagged: assert property (@(posedge clk) disable iff (rst)
        (dec_q == DEC_RUN && rx == prev_q) |=> line_error);

    a_r6_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        dout_valid |=> dout_valid);

    a_r6_prime_invalid: assert property (@(posedge clk) disable iff (rst)
        (dec_q == DEC_PRIME) |=> !base_vld);
endmodule

// File: rtl/twl_link.sv
`timescale 1ns/1ps
module twl_link
    import twl_pkg::*;
#(
    parameter int OUT_DELAY = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic chan_swap,
    input  logic chan_inv_a,
    input  logic chan_inv_b,
    input  logic chan_hold,
    output logic line_a,
    output logic line_b,
    output logic dout,
    output logic dout_valid,
    output logic line_error
);
    pair_t tx_pair;
    pair_t rx_pair;

    twl_encoder u_enc (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .line (tx_pair)
    );

    twl_channel u_chan (
        .clk   (clk),
        .rst   (rst),
        .tx    (tx_pair),
        .swap  (chan_swap),
        .inv_a (chan_inv_a),
        .inv_b (chan_inv_b),
        .hold  (chan_hold),
        .rx    (rx_pair)
    );

    twl_decoder #(.OUT_DELAY(OUT_DELAY)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .rx         (rx_pair),
        .dout       (dout),
        .dout_valid (dout_valid),
        .line_error (line_error)
    );

    assign line_a = tx_pair.a;
    assign line_b = tx_pair.b;
endmodule

// File: tb/test_twl_link.sv
`timescale 1ns/1ps
module test_twl_link;
    localparam int DLY = 1;
    localparam int NB  = 16;
    localparam logic [NB-1:0] PAT [8] = '{
        16'hFFFF, 16'h0000, 16'hAAAA, 16'h5555,
        16'h8001, 16'hF00F, 16'h3C96, 16'h0F71
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic sw = 1'b0, ia = 1'b0, ib = 1'b0, hold = 1'b0;
    logic line_a, line_b, dout, dout_valid, line_error;

    int n_chk = 0;
    int n_bad = 0;
    logic ea, eb, ealt;
    logic sent [NB+DLY+2];

    always #5 clk = ~clk;

    twl_link #(.OUT_DELAY(DLY)) i_twl_link (
        .clk(clk), .rst(rst), .din(din),
        .chan_swap(sw), .chan_inv_a(ia), .chan_inv_b(ib), .chan_hold(hold),
        .line_a(line_a), .line_b(line_b),
        .dout(dout), .dout_valid(dout_valid), .line_error(line_error)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; din = 1'b0; hold = 1'b0;
        repeat (2) @(negedge clk);
        check({line_a, line_b, dout, dout_valid, line_error} == 5'b0, "R4 reset state",
              {line_a, line_b, dout, dout_valid, line_error}, 0);
        rst = 1'b0;
        ea = 1'b0; eb = 1'b0; ealt = 1'b0;
    endtask

    // model of the line code per R2/R3
    task automatic model_step(input logic b);
        if (b) begin
            ea = ~ea; eb = ~eb;
        end else if (!ealt) begin
            ea = ~ea; ealt = 1'b1;
        end else begin
            eb = ~eb; ealt = 1'b0;
        end
    endtask

    task automatic run_pattern(input logic [NB-1:0] pat, input int cfg);
        logic pa, pb;
        for (int i = 0; i < NB + DLY + 1; i++) begin
            sent[i] = (i < NB) ? pat[i] : 1'b0;
            din = sent[i];
            pa = line_a; pb = line_b;
            @(negedge clk);
            model_step(sent[i]);
            check((line_a != pa) || (line_b != pb), "R1 line activity", {line_a, line_b}, {pa, pb});
            check({line_a, line_b} == {ea, eb}, sent[i] ? "R2 one encoding" : "R3 zero encoding",
                  {line_a, line_b}, {ea, eb});
            check(dout_valid == ((i + 1) > DLY), "R6 valid timing", dout_valid, (i + 1) > DLY);
            if ((i + 1) > DLY)
                check(dout == sent[i - DLY], $sformatf("R5/R7 data cfg=%0d", cfg), dout, sent[i - DLY]);
            check(line_error == 1'b0, "R9 no false error", line_error, 0);
        end
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // table walk: every channel configuration with its own pattern
        for (int k = 0; k < 8; k++) begin
            sw = k[0]; ia = k[1]; ib = k[2];
            do_reset();
            run_pattern(PAT[k], k);
        end

        // R3 alternation across interleaved ones: 0,1,0 toggles A, both, then B
        sw = 0; ia = 0; ib = 0;
        do_reset();
        din = 1'b0; @(negedge clk);
        check({line_a, line_b} == 2'b10, "R3 first zero on A", {line_a, line_b}, 2);
        din = 1'b1; @(negedge clk);
        check({line_a, line_b} == 2'b01, "R2 both toggle", {line_a, line_b}, 1);
        din = 1'b0; @(negedge clk);
        check({line_a, line_b} == 2'b00, "R3 second zero on B", {line_a, line_b}, 0);

        // R8: freeze the channel for one cycle, error sets and sticks
        din = 1'b1; @(negedge clk);
        din = 1'b0; @(negedge clk);
        check(line_error == 1'b0, "R9 error clear before hold", line_error, 0);
        hold = 1'b1; din = 1'b1;
        @(negedge clk);
        hold = 1'b0;
        check(line_error == 1'b1, "R8 error on frozen pair", line_error, 1);
        for (int j = 0; j < 4; j++) begin
            din = j[0];
            @(negedge clk);
            check(line_error == 1'b1, "R8 error sticky", line_error, 1);
        end

        // R4: reset clears the sticky error and the outputs
        do_reset();
        check(line_error == 1'b0, "R4 error cleared by reset", line_error, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule